// File: doc/BRIEF.md
# Eight-Channel Timer Compare and Pin Action Unit

This block watches a shared 16-bit free-running count and compares it against eight programmable 16-bit compare values. When a channel's value is reached, the channel raises a sticky status flag. If its interrupt enable is set, it also raises an interrupt request, and it can change a pin. Channels 0 to 6 each steer one pin with a two-bit action code. Channel 7 is the group channel: through a mask and a data byte, it can drive any subset of the eight pins at once, and it wins over the single-pin channels.

Software programs the unit through a simple write port. A force register lets software fire any channel's pin action at once, without waiting for the count. Forced actions never set a flag.

A match counts only on the cycle in which the count moves onto the compare value. A counter that is held or stopped therefore triggers once, not on every clock. All outputs are registered. A match or force presented in one cycle shows on the pins and flags after the next rising clock edge.

Top module: `ocmp_unit`

## Requirements
- R1: When `count_i` differs from its value in the previous cycle and equals channel n's compare value, flag n is 1 after the next clock edge.
- R2: A count that stays at a channel's compare value causes no further flag set or pin action. Pins change only after a count change or a force write.
- R3: Flags clear only by writing 1s to address 12 (bit n clears flag n). Written 0s leave flags unchanged. A set and a clear of the same flag in the same cycle leave the flag set.
- R4: `irq_o[n]` is 1 exactly when flag n is 1 and interrupt-enable bit n, written at address 11, is 1.
- R5: The action field of channel n (0..6) sits at bits [2n+1:2n] of address 8: 00 holds the pin, 01 toggles it, 10 drives it to 0, 11 drives it to 1. A channel acts only on pin n, and a disconnected channel still sets its flag.
- R6: A channel 7 event drives each pin whose bit is 1 in the mask (address 9) to the same bit of the data byte (address 10). Unmasked pins are untouched by channel 7.
- R7: When channel 7 and any of channels 0..6 act in the same cycle, the channel 7 value wins on every masked pin.
- R8: Writing a 1 to bit n of address 13 performs channel n's pin action at the next edge and never sets flag n.
- R9: A force and a real match on the same channel in the same cycle give one pin action and no flag set.
- R10: Reset drives all pins, flags and interrupt requests to 0 and clears every register to 0.
- R11: Addresses 0..7 hold the compare values of channels 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 16 | Shared free-running count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Write data |
| pin_o | output | 8 | Compare-driven pins |
| flag_o | output | 8 | Per-channel sticky status flags |
| irq_o | output | 8 | Per-channel interrupt requests |

## Verification
Every cycle, the checker enforces that interrupts never appear without their flag and that flags fall only after a clear write. It also enforces that flags rise and pins move only after a count change or a force, and that forced channels never gain a flag. The action codes need the bench's scenarios to show them. So do the group channel's mask override and its priority over a simultaneous single-pin toggle, the single toggle when force meets match, and set-over-clear, because these concern exact values rather than event causality.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    parameter int NCH = 8;
    parameter int CW  = 16;
    parameter int AW  = 4;
    parameter int DW  = 16;

    localparam int NSEL = NCH - 1;

    localparam logic [AW-1:0] A_SEL   = AW'(NCH);
    localparam logic [AW-1:0] A_MASK  = AW'(NCH + 1);
    localparam logic [AW-1:0] A_DATA  = AW'(NCH + 2);
    localparam logic [AW-1:0] A_IEN   = AW'(NCH + 3);
    localparam logic [AW-1:0] A_CLR   = AW'(NCH + 4);
    localparam logic [AW-1:0] A_FORCE = AW'(NCH + 5);

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;
endpackage

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
#(
    parameter int N = NCH,
    parameter int W = CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        count_i,
    input  logic [N-1:0][W-1:0] cmp_i,
    output logic [N-1:0]        hit_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = count_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a compare is valid only on the cycle the count moves
    assign tick = (count_i != st_q.cnt);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = tick && (count_i == cmp_i[g]);
    end
endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int N  = NCH,
    parameter int W  = CW,
    parameter int AWD = AW,
    parameter int DWD = DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [AWD-1:0]        wr_addr_i,
    input  logic [DWD-1:0]        wr_data_i,
    input  logic [N-1:0]          hit_i,
    output logic [N-1:0][W-1:0]   cmp_o,
    output logic [N-2:0][1:0]     sel_o,
    output logic [N-1:0]          mask_o,
    output logic [N-1:0]          data_o,
    output logic [N-1:0]          ien_o,
    output logic [N-1:0]          flag_o,
    output logic [N-1:0]          force_o
);
    localparam int SELW = 2 * (N - 1);

    typedef struct packed {
        logic [N-1:0][W-1:0] cmp;
        logic [N-2:0][1:0]   sel;
        logic [N-1:0]        mask;
        logic [N-1:0]        data;
        logic [N-1:0]        ien;
        logic [N-1:0]        flag;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] clr;
    logic [N-1:0] frc;

    assign clr = (wr_en_i && wr_addr_i == AWD'(A_CLR))   ? wr_data_i[N-1:0] : '0;
    assign frc = (wr_en_i && wr_addr_i == AWD'(A_FORCE)) ? wr_data_i[N-1:0] : '0;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int i = 0; i < N; i++) begin
                if (wr_addr_i == AWD'(i)) st_d.cmp[i] = wr_data_i[W-1:0];
            end
            if (wr_addr_i == AWD'(A_SEL))  st_d.sel  = wr_data_i[SELW-1:0];
            if (wr_addr_i == AWD'(A_MASK)) st_d.mask = wr_data_i[N-1:0];
            if (wr_addr_i == AWD'(A_DATA)) st_d.data = wr_data_i[N-1:0];
            if (wr_addr_i == AWD'(A_IEN))  st_d.ien  = wr_data_i[N-1:0];
        end
        // a new set outranks a clear in the same cycle; forced channels never set
        st_d.flag = (st_q.flag & ~clr) | (hit_i & ~frc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o   = st_q.cmp;
    assign sel_o   = st_q.sel;
    assign mask_o  = st_q.mask;
    assign data_o  = st_q.data;
    assign ien_o   = st_q.ien;
    assign flag_o  = st_q.flag;
    assign force_o = frc;
endmodule

// File: rtl/ocmp_pins.sv
module ocmp_pins
    import ocmp_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      hit_i,
    input  logic [N-1:0]      force_i,
    input  logic [N-2:0][1:0] sel_i,
    input  logic [N-1:0]      mask_i,
    input  logic [N-1:0]      data_i,
    output logic [N-1:0]      pin_o
);
    typedef struct packed {
        logic [N-1:0] pin;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] evt;
    logic [N-1:0] single;

    assign evt = hit_i | force_i;

    // per-pin result of the single-pin channels; the top pin has none
    for (genvar g = 0; g < N - 1; g++) begin : g_single
        always_comb begin
            single[g] = st_q.pin[g];
            if (evt[g]) begin
                case (act_e'(sel_i[g]))
                    ACT_TOG:  single[g] = ~st_q.pin[g];
                    ACT_LOW:  single[g] = 1'b0;
                    ACT_HIGH: single[g] = 1'b1;
                    default:  single[g] = st_q.pin[g];
                endcase
            end
        end
    end
    assign single[N-1] = st_q.pin[N-1];

    always_comb begin
        st_d     = st_q;
        st_d.pin = single;
        if (evt[N-1]) st_d.pin = (single & ~mask_i) | (data_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o = st_q.pin;
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] flag_o,
    output logic [NCH-1:0] irq_o
);
    logic [NCH-1:0][CW-1:0] cmp;
    logic [NCH-2:0][1:0]    sel;
    logic [NCH-1:0]         mask, data, ien, flag, frc, hit;

    ocmp_match #(.N(NCH), .W(CW)) u_match (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .cmp_i(cmp), .hit_o(hit)
    );

    ocmp_regs #(.N(NCH), .W(CW), .AWD(AW), .DWD(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .hit_i(hit),
        .cmp_o(cmp), .sel_o(sel), .mask_o(mask), .data_o(data),
        .ien_o(ien), .flag_o(flag), .force_o(frc)
    );

    ocmp_pins #(.N(NCH)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .hit_i(hit), .force_i(frc), .sel_i(sel),
        .mask_i(mask), .data_i(data), .pin_o(pin_o)
    );

    assign flag_o = flag;
    assign irq_o  = flag & ien;
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk
    import ocmp_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  count_i,
    input logic           wr_en_i,
    input logic [AW-1:0]  wr_addr_i,
    input logic [DW-1:0]  wr_data_i,
    input logic [NCH-1:0] pin_o,
    input logic [NCH-1:0] flag_o,
    input logic [NCH-1:0] irq_o
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~flag_o) == '0)); // R4

    AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && |(flag_o & ~$past(flag_o)))
        |-> ($past(count_i) != $past(count_i, 2))); // R2

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_FORCE)
        |=> ((flag_o & ~$past(flag_o) & $past(wr_data_i[NCH-1:0])) == '0)); // R8

    AST_FLAG_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && |($past(flag_o) & ~flag_o))
        |-> $past(wr_en_i && wr_addr_i == A_CLR)); // R3

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && $past(count_i) == $past(count_i, 2)
         && !$past(wr_en_i && wr_addr_i == A_FORCE))
        |-> $stable(pin_o)); // R2
endmodule

bind ocmp_unit ocmp_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .count_i(count_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/ocmp_unit_bench.sv
module ocmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [7:0]  pin_o, flag_o, irq_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ocmp_unit u_ocmp_unit (
        .clk(clk), .rst_n(rst_n), .count_i(count_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] cnt;
        logic [7:0]  pin;
        logic [7:0]  flag;
        logic [7:0]  irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    // addr: 0..7 compare, 8 action, 9 mask, 10 data, 11 irq enable, 12 clear, 13 force
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 4'd0,  16'h0010, 16'h0000, 8'h00, 8'h00, 8'h00, 8'd11}, // R11
        '{1'b1, 4'd8,  16'h002D, 16'h0000, 8'h00, 8'h00, 8'h00, 8'd5},  // R5 ch0 tog, ch1 high, ch2 low
        '{1'b1, 4'd1,  16'h0010, 16'h0000, 8'h00, 8'h00, 8'h00, 8'd11},
        '{1'b1, 4'd2,  16'h0020, 16'h0000, 8'h00, 8'h00, 8'h00, 8'd11},
        '{1'b1, 4'd11, 16'h0001, 16'h0000, 8'h00, 8'h00, 8'h00, 8'd4},
        '{1'b0, 4'd0,  16'h0000, 16'h0010, 8'h03, 8'h03, 8'h01, 8'd1},  // R1 R5 R4
        '{1'b0, 4'd0,  16'h0000, 16'h0010, 8'h03, 8'h03, 8'h01, 8'd2},  // R2 held count
        '{1'b1, 4'd12, 16'h0001, 16'h0010, 8'h03, 8'h02, 8'h00, 8'd3},  // R3 clear
        '{1'b1, 4'd12, 16'h0000, 16'h0010, 8'h03, 8'h02, 8'h00, 8'd3},  // R3 zeros ignored
        '{1'b0, 4'd0,  16'h0000, 16'h0011, 8'h03, 8'h02, 8'h00, 8'd2},
        '{1'b0, 4'd0,  16'h0000, 16'h0010, 8'h02, 8'h03, 8'h01, 8'd5},  // R5 toggle back
        '{1'b1, 4'd9,  16'h0085, 16'h0010, 8'h02, 8'h03, 8'h01, 8'd6},
        '{1'b1, 4'd10, 16'h0084, 16'h0010, 8'h02, 8'h03, 8'h01, 8'd6},
        '{1'b1, 4'd7,  16'h0030, 16'h0010, 8'h02, 8'h03, 8'h01, 8'd11},
        '{1'b1, 4'd0,  16'h0030, 16'h0010, 8'h02, 8'h03, 8'h01, 8'd11},
        '{1'b0, 4'd0,  16'h0000, 16'h0030, 8'h86, 8'h83, 8'h01, 8'd7},  // R7 R6
        '{1'b1, 4'd13, 16'h0004, 16'h0030, 8'h82, 8'h83, 8'h01, 8'd8},  // R8 force low
        '{1'b1, 4'd7,  16'h0040, 16'h0031, 8'h82, 8'h83, 8'h01, 8'd11},
        '{1'b1, 4'd12, 16'h00FF, 16'h0031, 8'h82, 8'h00, 8'h00, 8'd3},
        '{1'b1, 4'd13, 16'h0001, 16'h0030, 8'h83, 8'h00, 8'h00, 8'd9},  // R9 single toggle
        '{1'b1, 4'd11, 16'h00FF, 16'h0030, 8'h83, 8'h00, 8'h00, 8'd4},
        '{1'b0, 4'd0,  16'h0000, 16'h0040, 8'h86, 8'h80, 8'h80, 8'd6},  // R6 group alone
        '{1'b1, 4'd8,  16'h0000, 16'h0040, 8'h86, 8'h80, 8'h80, 8'd5},
        '{1'b0, 4'd0,  16'h0000, 16'h0010, 8'h86, 8'h82, 8'h82, 8'd5},  // R5 disconnected
        '{1'b1, 4'd12, 16'h0004, 16'h0020, 8'h86, 8'h86, 8'h86, 8'd3},  // R3 set wins
        '{1'b1, 4'd10, 16'h0000, 16'h0020, 8'h86, 8'h86, 8'h86, 8'd6},
        '{1'b1, 4'd13, 16'h0080, 16'h0020, 8'h02, 8'h86, 8'h86, 8'd8},  // R8 group force
        '{1'b1, 4'd12, 16'h0002, 16'h0020, 8'h02, 8'h84, 8'h84, 8'd3}
    };

    task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        wr_en_i   = v.wr;
        wr_addr_i = v.addr;
        wr_data_i = v.data;
        count_i   = v.cnt;
        @(posedge clk);
        #2;
        chk("pin",  int'(v.req), pin_o,  v.pin);
        chk("flag", int'(v.req), flag_o, v.flag);
        chk("irq",  int'(v.req), irq_o,  v.irq);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        chk("reset pin",  10, pin_o,  8'h00);
        chk("reset flag", 10, flag_o, 8'h00);
        chk("reset irq",  10, irq_o,  8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R10 reset mid-run clears everything
        @(negedge clk);
        wr_en_i = 1'b0;
        rst_n = 1'b0;
        #2;
        chk("rerst pin",  10, pin_o,  8'h00);
        chk("rerst flag", 10, flag_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step('{1'b0, 4'd0, 16'h0000, 16'h0010, 8'h00, 8'h00, 8'h00, 8'd10});
        // R1 all compare values reset to 0; enables and mask reset to 0
        step('{1'b0, 4'd0, 16'h0000, 16'h0000, 8'h00, 8'hFF, 8'h00, 8'd1});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule